// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block turns a bank of active-low request lines into the binary index of the highest-numbered request, with that index presented in complemented form. The basic unit is an eight-input slice. Each slice has an active-low enable, an active-low group flag that shows it found a request, and an active-low enable output. The enable output hands priority down to the next slice only when this slice is enabled and sees no request.

The top level chains a parameterised number of slices. The slice with the highest-numbered inputs takes the external enable, and each slice's enable output feeds the enable of the slice below it. The slice codes and the position of the slice that found a request are merged into one wide complemented index. The whole block is combinational. Its outputs follow its inputs with no clock and no storage.

Top module: `prioChain`

## Requirements
- R1: Every request input, the enable input and every output is active-low: a line is asserted when it is 0.
- R2: With the enable input high, the code outputs, the group flag and the enable output are all 1, whatever the request inputs are.
- R3: Within a slice, the highest-numbered asserted request wins and all lower-numbered requests are ignored.
- R4: A slice code is the bitwise complement of the 3-bit index of the winning request: request 7 gives 000 and request 0 gives 111.
- R5: A slice's group flag is 0 exactly when the slice is enabled and at least one of its requests is 0.
- R6: A slice's enable output is 0 exactly when the slice is enabled and none of its requests is 0.
- R7: An enabled slice with no asserted request drives code 111 and group flag 1.
- R8: In the chain, slice NUM_SLICES-1 holds the top request bits reqN[8*NUM_SLICES-1 -: 8] and takes enInN. Each slice's enable output drives the enable of the slice below it, so a higher slice's request always wins over any lower slice's request, and at most one slice has its group flag at 0.
- R9: The wide code codeN is the bitwise complement of (s*8 + k), where s is the slice that found a request and k is the winning index inside it. The slice number forms the upper bits and k forms the low 3 bits. When no slice finds a request, codeN is all ones.
- R10: The overall group flag grpN is the AND of all slice group flags. The overall enable output enOutN is the enable output of slice 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enInN | input | 1 | Active-low enable for the whole chain |
| reqN | input | 8*NUM_SLICES | Active-low request lines; bit i is request i |
| codeN | output | 3+clog2(NUM_SLICES) | Complemented index of the winning request |
| grpN | output | 1 | Active-low: some request was found |
| enOutN | output | 1 | Active-low: enabled and no request anywhere |

## Verification
The embedded assertions check a set of relations on every input change. A disabled slice drives all ones. A slice never has its group flag and its enable output low at the same time. An asserted top request forces code 000. At most one slice in the chain claims a request, and the wide code is all ones whenever the overall group flag is high. Only the bench sweeps can show that the right request wins and that the complemented index values are correct, since those depend on the full input pattern. The bench runs every pattern of a single slice with both enable values, and every 16-bit pattern of a two-slice chain, checking each against a highest-set-bit model.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
  // strobes from the slice control half to the slice data half
  typedef struct packed {
    logic sliceOn;  // slice enable asserted
    logic anyReq;   // at least one request asserted
  } sliceStrobe_t;
endpackage

// File: rtl/prioSliceCtrl.sv
module prioSliceCtrl
  import prio_enc_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic            enInN,
  input  logic [IN_W-1:0] reqN,
  output sliceStrobe_t    strobe,
  output logic            grpN,
  output logic            enOutN
);
  logic anyReq;
  logic sliceOn;

  always_comb begin
    anyReq  = |(~reqN);
    sliceOn = ~enInN;
    strobe.sliceOn = sliceOn;
    strobe.anyReq  = anyReq;
    grpN   = ~(sliceOn & anyReq);
    enOutN = ~(sliceOn & ~anyReq);
  end
endmodule

// File: rtl/prioSliceData.sv
module prioSliceData
  import prio_enc_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int CODE_W = $clog2(IN_W)
) (
  input  logic [IN_W-1:0]   reqN,
  input  sliceStrobe_t      strobe,
  output logic [CODE_W-1:0] codeN
);
  logic [CODE_W-1:0] winIdx;

  always_comb begin
    winIdx = '0;
    // ascending scan: a later (higher) asserted request overwrites earlier ones
    for (int i = 0; i < IN_W; i++) begin
      if (!reqN[i]) winIdx = CODE_W'(i);
    end
    codeN = (strobe.sliceOn && strobe.anyReq) ? ~winIdx : '1;
  end

  // R3: top request asserted on an enabled slice forces the all-zero code
  always_comb begin
    if (strobe.sliceOn && !reqN[IN_W-1])
      a_r3_top_wins: assert (codeN == '0);
  end
endmodule

// File: rtl/prioSlice.sv
module prioSlice
  import prio_enc_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int CODE_W = $clog2(IN_W)
) (
  input  logic              enInN,
  input  logic [IN_W-1:0]   reqN,
  output logic [CODE_W-1:0] codeN,
  output logic              grpN,
  output logic              enOutN
);
  sliceStrobe_t strobe;

  prioSliceCtrl #(.IN_W(IN_W)) ctrl (
    .enInN (enInN),
    .reqN  (reqN),
    .strobe(strobe),
    .grpN  (grpN),
    .enOutN(enOutN)
  );

  prioSliceData #(.IN_W(IN_W), .CODE_W(CODE_W)) data (
    .reqN  (reqN),
    .strobe(strobe),
    .codeN (codeN)
  );

  // R2: disabled slice drives every output high
  always_comb begin
    if (enInN)
      a_r2_disabled_high: assert (codeN == '1 && grpN && enOutN);
  end

  // R5, R6: group flag and enable output never both asserted
  always_comb begin
    a_r6_grp_eo_exclusive: assert (grpN || enOutN);
  end

  // R7: without a group flag the code stays all ones
  always_comb begin
    if (grpN)
      a_r7_idle_code: assert (codeN == '1);
  end
endmodule

// File: rtl/prioChain.sv
module prioChain #(
  parameter int NUM_SLICES   = 2,
  parameter int SLICE_IN     = 8,
  parameter int SLICE_CODE_W = $clog2(SLICE_IN),
  parameter int SEL_W        = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 0,
  parameter int IDX_W        = SLICE_CODE_W + SEL_W
) (
  input  logic                         enInN,
  input  logic [NUM_SLICES*SLICE_IN-1:0] reqN,
  output logic [IDX_W-1:0]             codeN,
  output logic                         grpN,
  output logic                         enOutN
);
  logic [NUM_SLICES:0]     enVec;   // enVec[s+1] enables slice s
  logic [NUM_SLICES-1:0]   grpVec;
  logic [SLICE_CODE_W-1:0] sliceCode [NUM_SLICES];
  logic [SLICE_CODE_W-1:0] lowAnd;

  assign enVec[NUM_SLICES] = enInN;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    prioSlice #(.IN_W(SLICE_IN), .CODE_W(SLICE_CODE_W)) slice (
      .enInN (enVec[s+1]),
      .reqN  (reqN[s*SLICE_IN +: SLICE_IN]),
      .codeN (sliceCode[s]),
      .grpN  (grpVec[s]),
      .enOutN(enVec[s])
    );
  end

  // idle slices drive all ones, so AND keeps the single active code
  always_comb begin
    lowAnd = '1;
    for (int s = 0; s < NUM_SLICES; s++) lowAnd &= sliceCode[s];
  end

  if (SEL_W > 0) begin : g_wide
    logic [SEL_W-1:0] highAnd;
    always_comb begin
      highAnd = '1;
      for (int s = 0; s < NUM_SLICES; s++) begin
        if (!grpVec[s]) highAnd &= ~SEL_W'(s);
      end
    end
    assign codeN = {highAnd, lowAnd};
  end else begin : g_narrow
    assign codeN = lowAnd;
  end

  assign grpN   = &grpVec;
  assign enOutN = enVec[0];

  // R8: at most one slice claims a request
  always_comb begin
    a_r8_one_group: assert ($countones(~grpVec) <= 1);
  end

  // R9: no request found means an all-ones wide code
  always_comb begin
    if (grpN)
      a_r9_idle_wide: assert (codeN == '1);
  end

  // R10: overall group flag and enable output never both asserted
  always_comb begin
    a_r10_top_exclusive: assert (grpN || enOutN);
  end
endmodule

// File: tb/prioChain_test.sv
`timescale 1ns/1ps
module prioChain_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int fails  = 0;

  // two-slice chain under test
  logic        enA;
  logic [15:0] reqA;
  logic [3:0]  codeA;
  logic        grpA, eoA;

  // single slice configuration
  logic        enS;
  logic [7:0]  reqS;
  logic [2:0]  codeS;
  logic        grpS, eoS;

  prioChain #(.NUM_SLICES(2), .SLICE_IN(8)) uut (
    .enInN(enA), .reqN(reqA), .codeN(codeA), .grpN(grpA), .enOutN(eoA)
  );

  prioChain #(.NUM_SLICES(1), .SLICE_IN(8)) uutSingle (
    .enInN(enS), .reqN(reqS), .codeN(codeS), .grpN(grpS), .enOutN(eoS)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (en=%b reqA=%h reqS=%h)",
               tag, act, exp, enA, reqA, reqS);
    end
  endtask

  // highest asserted (zero) bit among the low w bits; -1 if none
  function automatic int topIdx(input logic [15:0] r, input int w);
    int idx = -1;
    for (int i = 0; i < w; i++) if (!r[i]) idx = i;
    return idx;
  endfunction

  task automatic checkSingle();
    int idx  = topIdx({8'hff, reqS}, 8);
    bit on   = !enS;
    int eCode = (on && idx >= 0) ? ((~idx) & 7) : 7;
    check(enS ? "R2 slice code" : "R3,R4 slice code", codeS, eCode);
    check(enS ? "R2 slice grp" : "R5 slice grp", grpS, (on && idx >= 0) ? 0 : 1);
    check(enS ? "R2 slice eo" : (idx < 0 ? "R7 R6 slice eo" : "R6 slice eo"),
          eoS, (on && idx < 0) ? 0 : 1);
  endtask

  task automatic checkChain();
    int idx  = topIdx(reqA, 16);
    bit on   = !enA;
    bit both = (reqA[15:8] != 8'hff) && (reqA[7:0] != 8'hff);
    int eCode = (on && idx >= 0) ? ((~idx) & 15) : 15;
    check(both ? "R8 R9 wide code" : "R9 wide code", codeA, eCode);
    check("R10 overall grp", grpA, (on && idx >= 0) ? 0 : 1);
    check("R10 overall eo", eoA, (on && idx < 0) ? 0 : 1);
  endtask

  initial begin
    #(8 * 199000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    enA = 1'b0; reqA = '1; enS = 1'b0; reqS = '1;
    @(negedge clk); #2;
    // R1: all lines high means nothing asserted; enabled idle outputs
    check("R1 idle code", codeA, 15);
    check("R1 idle grp", grpA, 1);
    check("R1 idle eo", eoA, 0);
    check("R7 idle slice code", codeS, 7);

    // single slice: every request pattern with both enable levels
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        enS = e[0]; reqS = p[7:0];
        #2 checkSingle();
      end
    end

    // two-slice chain: every request pattern while enabled
    for (int p = 0; p < 65536; p++) begin
      @(negedge clk);
      enA = 1'b0; reqA = p[15:0];
      #2 checkChain();
    end

    // chain disabled: random request patterns must have no effect
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      enA = 1'b1; reqA = 16'($urandom);
      #2;
      check("R2 chain disabled code", codeA, 15);
      check("R2 chain disabled grp", grpA, 1);
      check("R2 chain disabled eo", eoA, 1);
    end

    // one-hot asserted requests across the chain
    for (int b = 0; b < 16; b++) begin
      @(negedge clk);
      enA = 1'b0; reqA = ~(16'(1) << b);
      #2;
      check("R9 one-hot code", codeA, (~b) & 15);
      check("R8 one-hot grp", grpA, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule